// File: doc/BRIEF.md
# Virtual Address Region Fault Classifier

This block sits beside the load/store and fetch paths of a processor with a software-managed TLB. Each cycle that an access is presented, it decides whether the address passes straight through to physical memory, goes through the TLB, or is refused outright. For refused accesses it produces an exception cause code. The TLB lookup itself is done outside this block: the caller presents the hit flag, the read/write/execute permission bits and the 20-bit frame number of the matching entry in the same cycle as the address.

The 32-bit space has fixed regions. In supervisor mode the top quarter (0xC0000000 and above) is an identity window that ignores the TLB, and everything below it is translated. In user mode the whole upper half (0x80000000 and above) is forbidden, and the lower half is translated. When the MMU is configured off, every address is an identity mapping with no checks. Pages are 4 KB.

On every fault the block records the faulting address in a bad-address register. On TLB faults it also records the state a miss handler needs: the virtual page number is placed into a page-table-entry address register, whose page-table base field software sets and the block keeps, and a flag tells data accesses apart from fetches. Results are registered and appear one cycle after the access.

Top module: `vrc_top`

## Requirements
- R1: After reset every output is zero: no result pulse, bad-address register 0, page-table-entry address register 0, data-access flag 0.
- R2: With mmu_en_i low, every valid access gives bypass=1, xlate=0, fault=0, cause 0 and a physical address equal to the virtual address, whatever the mode, kind and TLB inputs.
- R3: In supervisor mode (user_mode_i=0) with the MMU on, an address at or above 0xC0000000 gives bypass=1 with an identity physical address and no fault, ignoring the TLB inputs.
- R4: A translated access (supervisor below 0xC0000000, or user below 0x80000000) gives xlate=1. On a hit with the needed permission its physical address is {tlb_frame_i, addr[11:0]} and no fault is raised.
- R5: In user mode with the MMU on, an address at or above 0x80000000 raises a fault with cause 9, xlate=0, bypass=0, and loads the bad-address register. The page-table-entry address register and the data-access flag are left unchanged.
- R6: A translated access with tlb_hit_i low raises cause 12.
- R7: A translated access that hits without the needed permission raises cause 14 for a read (kind 0, and kind 3, which is handled as a read, both check tlb_rd_ok_i), 15 for a write (kind 1, tlb_wr_ok_i) and 13 for a fetch (kind 2, tlb_ex_ok_i).
- R8: On a cause 12, 13, 14 or 15 fault the bad-address register takes the address, bits 21:2 of the page-table-entry address register take address bits 31:12, bits 31:22 keep the page-table base and bits 1:0 stay 0.
- R9: On a cause 12 to 15 fault the data-access flag becomes 1 for kinds 0, 1 and 3 and 0 for kind 2.
- R10: Results are a one-cycle pulse in the cycle after acc_valid_i. With acc_valid_i low, every res_* output is 0 in the following cycle, and the registers and the flag keep their values. A faulting access gives a physical address of 0.
- R11: pt_base_we_i loads pt_base_i into bits 31:22 of the page-table-entry address register at the next edge. This also works in the same cycle as a TLB fault, and both updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access presented this cycle |
| acc_addr_i | input | 32 | Virtual address |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| user_mode_i | input | 1 | 1 = user privilege, 0 = supervisor |
| mmu_en_i | input | 1 | MMU configured |
| tlb_hit_i | input | 1 | TLB lookup matched |
| tlb_rd_ok_i | input | 1 | Matching entry allows read |
| tlb_wr_ok_i | input | 1 | Matching entry allows write |
| tlb_ex_ok_i | input | 1 | Matching entry allows execute |
| tlb_frame_i | input | 20 | Physical frame number of matching entry |
| pt_base_we_i | input | 1 | Load page-table base field |
| pt_base_i | input | 10 | New page-table base |
| res_valid_o | output | 1 | Result pulse |
| res_bypass_o | output | 1 | Access used the identity mapping |
| res_xlate_o | output | 1 | Access was routed through the TLB |
| res_fault_o | output | 1 | Access faulted |
| res_cause_o | output | 5 | Exception cause, 0 when no fault |
| res_paddr_o | output | 32 | Physical address, 0 on fault |
| badaddr_o | output | 32 | Last faulting address |
| pteaddr_o | output | 32 | Page-table base and missed page number |
| data_flag_o | output | 1 | Last TLB fault was a data access |

## Verification
The sweep crosses addresses on both sides of the 0x80000000 and 0xC0000000 boundaries with every kind, both modes, MMU on and off, hit and miss, and all eight permission patterns. A design that moved a boundary by one page, or tested the wrong permission bit for a kind, would produce the wrong route or cause on a handful of those points. The bench tracks the handler registers across the sequence, so a design that let a user privilege fault overwrite the page number or the data flag, cleared the page-table base on a miss, or inverted the fetch flag gets caught on the next check. Idle cycles and a base write that coincides with a miss check that results do not linger and that the two register updates do not overwrite each other.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RT_BYPASS = 2'd0,
    RT_XLATE  = 2'd1,
    RT_PRIV   = 2'd2
  } route_e;

  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE       = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV_ADDR  = 5'd9;
  localparam logic [CAUSE_W-1:0] CAUSE_TLB_MISS   = 5'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_PERM_EXEC  = 5'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_PERM_READ  = 5'd14;
  localparam logic [CAUSE_W-1:0] CAUSE_PERM_WRITE = 5'd15;
endpackage

// File: rtl/vrc_region_map.sv
module vrc_region_map
  import vrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              user_i,
  input  logic              mmu_en_i,
  output route_e            route_o
);
  logic in_bypass, in_priv;
  assign in_bypass = (addr_i >= BYPASS_BASE);
  assign in_priv   = (addr_i >= USER_LIMIT);

  always_comb begin
    if (!mmu_en_i)      route_o = RT_BYPASS;
    else if (user_i)    route_o = in_priv ? RT_PRIV : RT_XLATE;
    else                route_o = in_bypass ? RT_BYPASS : RT_XLATE;
  end
endmodule

// File: rtl/vrc_perm_judge.sv
module vrc_perm_judge
  import vrc_pkg::*;
(
  input  logic [1:0]         kind_i,
  input  logic               hit_i,
  input  logic               rd_ok_i,
  input  logic               wr_ok_i,
  input  logic               ex_ok_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int unsigned NKIND = 4;
  logic [NKIND-1:0]         allow_v;
  logic [CAUSE_W-1:0]       deny_cause [NKIND];

  // per-kind permission select and denial code
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    if (k == int'(ACC_WRITE)) begin : g_wr
      assign allow_v[k]    = wr_ok_i;
      assign deny_cause[k] = CAUSE_PERM_WRITE;
    end else if (k == int'(ACC_FETCH)) begin : g_ex
      assign allow_v[k]    = ex_ok_i;
      assign deny_cause[k] = CAUSE_PERM_EXEC;
    end else begin : g_rd
      assign allow_v[k]    = rd_ok_i;
      assign deny_cause[k] = CAUSE_PERM_READ;
    end
  end

  always_comb begin
    if (!hit_i) begin
      fault_o = 1'b1;
      cause_o = CAUSE_TLB_MISS;
    end else if (!allow_v[kind_i]) begin
      fault_o = 1'b1;
      cause_o = deny_cause[kind_i];
    end else begin
      fault_o = 1'b0;
      cause_o = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/vrc_fault_capture.sv
module vrc_fault_capture
  import vrc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned VPN_W    = ADDR_W - PAGE_BITS,
  localparam int unsigned PTB_W    = ADDR_W - VPN_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlate_fault_i,
  input  logic              priv_fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        kind_i,
  input  logic              base_we_i,
  input  logic [PTB_W-1:0]  base_i,
  output logic [ADDR_W-1:0] badaddr_o,
  output logic [ADDR_W-1:0] pteaddr_o,
  output logic              data_flag_o
);
  logic [PTB_W-1:0] base_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      badaddr_o   <= '0;
      base_q      <= '0;
      vpn_q       <= '0;
      data_flag_o <= 1'b0;
    end else begin
      if (xlate_fault_i || priv_fault_i) badaddr_o <= addr_i;
      if (xlate_fault_i) begin
        vpn_q       <= addr_i[ADDR_W-1:PAGE_BITS];
        data_flag_o <= (kind_i != ACC_FETCH);
      end
      if (base_we_i) base_q <= base_i;
    end
  end

  assign pteaddr_o = {base_q, vpn_q, 2'b00};
endmodule

// File: rtl/vrc_top.sv
module vrc_top
  import vrc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000,
  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS,
  localparam int unsigned PTB_W   = PAGE_BITS - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [1:0]         acc_kind_i,
  input  logic               user_mode_i,
  input  logic               mmu_en_i,
  input  logic               tlb_hit_i,
  input  logic               tlb_rd_ok_i,
  input  logic               tlb_wr_ok_i,
  input  logic               tlb_ex_ok_i,
  input  logic [FRAME_W-1:0] tlb_frame_i,
  input  logic               pt_base_we_i,
  input  logic [PTB_W-1:0]   pt_base_i,
  output logic               res_valid_o,
  output logic               res_bypass_o,
  output logic               res_xlate_o,
  output logic               res_fault_o,
  output logic [CAUSE_W-1:0] res_cause_o,
  output logic [ADDR_W-1:0]  res_paddr_o,
  output logic [ADDR_W-1:0]  badaddr_o,
  output logic [ADDR_W-1:0]  pteaddr_o,
  output logic               data_flag_o
);
  route_e             route;
  logic               tlb_fault;
  logic [CAUSE_W-1:0] tlb_cause;
  logic               xlate_fault, priv_fault;

  vrc_region_map #(
    .ADDR_W(ADDR_W), .BYPASS_BASE(BYPASS_BASE), .USER_LIMIT(USER_LIMIT)
  ) u_map (
    .addr_i(acc_addr_i), .user_i(user_mode_i), .mmu_en_i(mmu_en_i), .route_o(route)
  );

  vrc_perm_judge u_judge (
    .kind_i(acc_kind_i), .hit_i(tlb_hit_i), .rd_ok_i(tlb_rd_ok_i),
    .wr_ok_i(tlb_wr_ok_i), .ex_ok_i(tlb_ex_ok_i),
    .fault_o(tlb_fault), .cause_o(tlb_cause)
  );

  assign xlate_fault = acc_valid_i && (route == RT_XLATE) && tlb_fault;
  assign priv_fault  = acc_valid_i && (route == RT_PRIV);

  vrc_fault_capture #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .xlate_fault_i(xlate_fault), .priv_fault_i(priv_fault),
    .addr_i(acc_addr_i), .kind_i(acc_kind_i),
    .base_we_i(pt_base_we_i), .base_i(pt_base_i),
    .badaddr_o(badaddr_o), .pteaddr_o(pteaddr_o), .data_flag_o(data_flag_o)
  );

  logic [ADDR_W-1:0]  paddr_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    paddr_d = '0;
    cause_d = CAUSE_NONE;
    unique case (route)
      RT_BYPASS: paddr_d = acc_addr_i;
      RT_XLATE: begin
        if (tlb_fault) cause_d = tlb_cause;
        else           paddr_d = {tlb_frame_i, acc_addr_i[PAGE_BITS-1:0]};
      end
      default: cause_d = CAUSE_PRIV_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_bypass_o <= 1'b0;
      res_xlate_o  <= 1'b0;
      res_fault_o  <= 1'b0;
      res_cause_o  <= CAUSE_NONE;
      res_paddr_o  <= '0;
    end else begin
      res_valid_o  <= acc_valid_i;
      res_bypass_o <= acc_valid_i && (route == RT_BYPASS);
      res_xlate_o  <= acc_valid_i && (route == RT_XLATE);
      res_fault_o  <= xlate_fault || priv_fault;
      res_cause_o  <= acc_valid_i ? cause_d : CAUSE_NONE;
      res_paddr_o  <= acc_valid_i ? paddr_d : '0;
    end
  end
endmodule

// File: rtl/vrc_checker.sv
module vrc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_valid_i,
  input logic [31:0] acc_addr_i,
  input logic [1:0]  acc_kind_i,
  input logic        user_mode_i,
  input logic        mmu_en_i,
  input logic        tlb_hit_i,
  input logic        res_valid_o,
  input logic        res_bypass_o,
  input logic        res_fault_o,
  input logic [4:0]  res_cause_o,
  input logic [31:0] res_paddr_o,
  input logic [31:0] badaddr_o,
  input logic [31:0] pteaddr_o,
  input logic        data_flag_o
);
  logic xl_region;
  assign xl_region = user_mode_i ? !acc_addr_i[31] : (acc_addr_i[31:30] != 2'b11);

  a_r10_pulse_follows_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(acc_valid_i));

  a_r2_no_mmu_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !mmu_en_i |=> res_bypass_o && !res_fault_o && res_paddr_o == $past(acc_addr_i));

  a_r5_user_upper_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && mmu_en_i && user_mode_i && acc_addr_i[31]
      |=> res_fault_o && res_cause_o == 5'd9 && badaddr_o == $past(acc_addr_i));

  a_r6_miss_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && mmu_en_i && xl_region && !tlb_hit_i |=> res_fault_o && res_cause_o == 5'd12);

  a_r8_vpn_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && mmu_en_i && xl_region && !tlb_hit_i |=> pteaddr_o[21:2] == $past(acc_addr_i[31:12]));

  a_r9_data_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && mmu_en_i && xl_region && !tlb_hit_i |=> data_flag_o == ($past(acc_kind_i) != 2'd2));

  a_r10_badaddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_fault_o |-> $stable(badaddr_o));
endmodule

bind vrc_top vrc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
  .acc_kind_i(acc_kind_i), .user_mode_i(user_mode_i), .mmu_en_i(mmu_en_i),
  .tlb_hit_i(tlb_hit_i), .res_valid_o(res_valid_o), .res_bypass_o(res_bypass_o),
  .res_fault_o(res_fault_o), .res_cause_o(res_cause_o), .res_paddr_o(res_paddr_o),
  .badaddr_o(badaddr_o), .pteaddr_o(pteaddr_o), .data_flag_o(data_flag_o)
);

// File: tb/sim_vrc_top.sv
module sim_vrc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        user_mode = 1'b0, mmu_en = 1'b0, tlb_hit = 1'b0;
  logic        rd_ok = 1'b0, wr_ok = 1'b0, ex_ok = 1'b0;
  logic [19:0] frame = '0;
  logic        base_we = 1'b0;
  logic [9:0]  base_val = '0;

  logic        r_valid, r_bypass, r_xlate, r_fault, dflag;
  logic [4:0]  r_cause;
  logic [31:0] r_paddr, badaddr, pteaddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_bad = '0;
  logic [19:0] m_vpn = '0;
  logic [9:0]  m_base = '0;
  logic        m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_kind_i(acc_kind), .user_mode_i(user_mode), .mmu_en_i(mmu_en),
    .tlb_hit_i(tlb_hit), .tlb_rd_ok_i(rd_ok), .tlb_wr_ok_i(wr_ok), .tlb_ex_ok_i(ex_ok),
    .tlb_frame_i(frame), .pt_base_we_i(base_we), .pt_base_i(base_val),
    .res_valid_o(r_valid), .res_bypass_o(r_bypass), .res_xlate_o(r_xlate),
    .res_fault_o(r_fault), .res_cause_o(r_cause), .res_paddr_o(r_paddr),
    .badaddr_o(badaddr), .pteaddr_o(pteaddr), .data_flag_o(dflag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, "badaddr", badaddr, m_bad);
    chk(req, "pteaddr", pteaddr, {m_base, m_vpn, 2'b00});
    chk(req, "data_flag", {31'd0, dflag}, {31'd0, m_flag});
  endtask

  // one access: drive at negedge, check at next negedge
  task automatic do_acc(input logic [31:0] a, input logic [1:0] k, input logic u, input logic m,
                        input logic h, input logic [2:0] p, input logic [19:0] f,
                        input logic bwe, input logic [9:0] bv);
    logic e_byp, e_xl, e_flt;
    logic [4:0] e_cause;
    logic [31:0] e_pa;
    logic allow;
    string rq;
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; user_mode = u; mmu_en = m;
    tlb_hit = h; rd_ok = p[0]; wr_ok = p[1]; ex_ok = p[2]; frame = f;
    base_we = bwe; base_val = bv;
    e_byp = 0; e_xl = 0; e_flt = 0; e_cause = 0; e_pa = 0;
    if (!m) begin e_byp = 1; e_pa = a; rq = "R2"; end
    else if (u && a >= 32'h8000_0000) begin e_flt = 1; e_cause = 9; rq = "R5"; end
    else if (!u && a >= 32'hC000_0000) begin e_byp = 1; e_pa = a; rq = "R3"; end
    else begin
      e_xl = 1;
      allow = (k == 2'd1) ? p[1] : (k == 2'd2) ? p[2] : p[0];
      if (!h) begin e_flt = 1; e_cause = 12; rq = "R6"; end
      else if (!allow) begin
        e_flt = 1; e_cause = (k == 2'd1) ? 5'd15 : (k == 2'd2) ? 5'd13 : 5'd14; rq = "R7";
      end else begin e_pa = {f, a[11:0]}; rq = "R4"; end
    end
    if (bwe) m_base = bv;
    if (e_flt) m_bad = a;
    if (e_flt && e_xl) begin m_vpn = a[31:12]; m_flag = (k != 2'd2); end
    @(negedge clk);
    chk("R10", "res_valid", {31'd0, r_valid}, 32'd1);
    chk(rq, "bypass", {31'd0, r_bypass}, {31'd0, e_byp});
    chk(rq, "xlate", {31'd0, r_xlate}, {31'd0, e_xl});
    chk(rq, "fault", {31'd0, r_fault}, {31'd0, e_flt});
    chk(rq, "cause", {27'd0, r_cause}, {27'd0, e_cause});
    chk(rq, "paddr", r_paddr, e_pa);
    if (e_flt && e_xl) chk_state(bwe ? "R11" : "R8");
    else if (e_flt)    chk_state("R5");
    else               chk_state(bwe ? "R11" : "R9");
    base_we = 1'b0;
  endtask

  task automatic idle();
    acc_valid = 1'b0;
    acc_addr = 32'hDEAD_BEEF; mmu_en = 1'b1; user_mode = 1'b1; tlb_hit = 1'b0;
    @(negedge clk);
    chk("R10", "idle res_valid", {31'd0, r_valid}, 32'd0);
    chk("R10", "idle fault", {31'd0, r_fault}, 32'd0);
    chk("R10", "idle cause/paddr", {27'd0, r_cause} | r_paddr, 32'd0);
    chk("R10", "idle bypass/xlate", {30'd0, r_bypass, r_xlate}, 32'd0);
    chk_state("R10");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] addrs [8];
    int n;
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h0000_1FFF; addrs[2] = 32'h7FFF_FFFF;
    addrs[3] = 32'h8000_0000; addrs[4] = 32'hA5A5_3C21; addrs[5] = 32'hBFFF_FFFF;
    addrs[6] = 32'hC000_0000; addrs[7] = 32'hFFFF_F123;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", {31'd0, r_valid}, 32'd0);
    chk("R1", "res_fault", {31'd0, r_fault}, 32'd0);
    chk("R1", "res_paddr", r_paddr, 32'd0);
    chk_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    for (int ai = 0; ai < 8; ai++)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          for (int m = 0; m < 2; m++)
            for (int h = 0; h < 2; h++)
              for (int p = 0; p < 8; p++) begin
                n++;
                do_acc(addrs[ai] ^ {20'd0, n[11:0]} & {20'd0, 12'hFFF} & {32{ai != 3 && ai != 6}},
                       2'(k), 1'(u), 1'(m), 1'(h), 3'(p),
                       addrs[ai][31:12] ^ 20'h5A5A5 ^ 20'(n),
                       (n % 37) == 0, 10'(n * 7));
                if ((n % 16) == 0) idle();
              end
    // R11: base write coinciding with a user-mode miss
    do_acc(32'h1234_5678, 2'd2, 1'b1, 1'b1, 1'b0, 3'd7, 20'h0, 1'b1, 10'h3A5);
    idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule